// File: doc/BRIEF.md
# Write-Protection Key Sequence Detector

This block sits beside the write controller of a byte-wide non-volatile array. It sees every write the controller accepts, as an address and data pair with a one-cycle strobe. It looks for three magic write sequences. A three-write arming key turns write protection on. A six-write release key turns it off. While protection is on, the same three-write key opens one page window in which data writes reach the array, and protection stays on afterwards.

For each accepted write the block answers, in the same cycle, whether the controller may commit that byte to the array. Writes that the detector consumes as key steps are never committed. The controller owns the page-load timer and signals its expiry with a single-cycle pulse. That pulse closes an open page window and abandons any half-entered key.

The protect flag models a retained cell. Reset does not touch it, and its power-on value is a parameter. Reset only returns the sequence detector to idle.

Top module: `wpk_guard`

## Requirements
- R1: After reset the flag `prot_o` equals the parameter `INIT_PROT` (default 0, meaning unprotected), and with `wr_valid` low `commit_ok` is low.
- R2: While unprotected, an accepted write that is not consumed as a key step has `commit_ok` high in the same cycle as `wr_valid`; `commit_ok` is never high without `wr_valid`.
- R3: Three consecutive accepted writes, data AAh at address 1555h, then 55h at 0AAAh, then A0h at 1555h, with no timer expiry between them, set `prot_o` to 1 from the cycle after the third write.
- R4: A write consumed as a key step (any step of either key) never has `commit_ok` high, whether protected or not.
- R5: While protected and outside an open page window, every accepted write has `commit_ok` low.
- R6: After the three-write arming key completes, protected or not, every following accepted write commits, including ones whose pattern looks like a key. This lasts until a `win_expire` pulse; after that, protected writes are blocked again.
- R7: Six consecutive accepted writes, AAh@1555h, 55h@0AAAh, 80h@1555h, AAh@1555h, 55h@0AAAh, 20h@1555h, clear `prot_o` to 0 from the cycle after the sixth write.
- R8: A write that does not match the next expected key step returns the detector to idle. If that write is AAh@1555h, it counts as a new first step.
- R9: A `win_expire` pulse abandons a partial key. A write presented in the same cycle as the pulse is judged as if the detector were idle.
- R10: Synchronous active-low reset abandons a partial key and holds `commit_ok` low, and it leaves `prot_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the detector |
| wr_valid | input | 1 | One-cycle strobe of an accepted write |
| wr_addr | input | ADDR_W (13) | Address of the accepted write |
| wr_data | input | DATA_W (8) | Data of the accepted write |
| win_expire | input | 1 | One-cycle pulse: page-load timer ran out |
| prot_o | output | 1 | Write protection flag, 1 = protected |
| commit_ok | output | 1 | Current write may be committed to the array |

## Verification
The main function is exercised with several key patterns:
- complete arming keys from both the protected and the unprotected state;
- the full six-write release key, applied both when protected and when already unprotected;
- keys broken by a wrong byte, by a repeated lead byte, by a timer pulse, and by reset.

Each broken-key pattern tells apart a detector that merely counts writes from one that checks every step. The page writes that follow a broken key show whether a stale partial key can still open a window. A write issued together with the timer pulse separates "expiry first" from "write first" ordering. A reset in mid-key separates the retained flag from the volatile sequence state.

// File: rtl/wpk_pkg.sv
// Shared types for the write-protection key detector.
// Assumes: five distinct key codes (address/data pairs) cover both keys.
package wpk_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,   // no key in progress
        SQ_K1   = 3'd1,   // lead byte seen
        SQ_K2   = 3'd2,   // lead and middle bytes seen
        SQ_D3   = 3'd3,   // release key, third step seen
        SQ_D4   = 3'd4,   // release key, fourth step seen
        SQ_D5   = 3'd5,   // release key, fifth step seen
        SQ_PASS = 3'd6    // page window open after arming key
    } sq_state_t;

    localparam int NCODE  = 5;
    localparam int C_LEAD = 0;   // AAh at the high key address
    localparam int C_MID  = 1;   // 55h at the low key address
    localparam int C_SET  = 2;   // A0h at the high key address
    localparam int C_ARM  = 3;   // 80h at the high key address
    localparam int C_CLR  = 4;   // 20h at the high key address

endpackage

// File: rtl/wpk_code_match.sv
// Compares one write against a table of key codes and returns a hit vector.
// Assumes: codes are distinct, so at most one bit of hit is set.
module wpk_code_match #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8,
    parameter int NC     = 5
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W-1:0]         data,
    input  logic [NC-1:0][ADDR_W-1:0] code_addr,
    input  logic [NC-1:0][DATA_W-1:0] code_data,
    output logic [NC-1:0]             hit
);

    // One equality comparator per key code.
    for (genvar i = 0; i < NC; i++) begin : g_cmp
        assign hit[i] = (addr == code_addr[i]) && (data == code_data[i]);
    end

endmodule

// File: rtl/wpk_seq_fsm.sv
// Key sequence state machine. It walks the arming and release keys, opens
// the page window and flags key-step writes.
// Assumes: win_expire is a one-cycle pulse and is applied before the
// write seen in the same cycle.
module wpk_seq_fsm
    import wpk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid,
    input  logic             win_expire,
    input  logic [NCODE-1:0] hit,
    output logic             set_req,
    output logic             clr_req,
    output logic             key_step,
    output logic             pass_eff
);

    sq_state_t st_q, eff, nxt;

    // Next state and decode for the write presented in this cycle.
    always_comb begin
        eff      = win_expire ? SQ_IDLE : st_q;
        nxt      = eff;
        set_req  = 1'b0;
        clr_req  = 1'b0;
        key_step = 1'b0;
        if (wr_valid) begin
            unique case (eff)
                SQ_IDLE: begin
                    if (hit[C_LEAD]) begin nxt = SQ_K1; key_step = 1'b1; end
                end
                SQ_K1: begin
                    if (hit[C_MID])       begin nxt = SQ_K2; key_step = 1'b1; end
                    else if (hit[C_LEAD]) begin nxt = SQ_K1; key_step = 1'b1; end
                    else                        nxt = SQ_IDLE;
                end
                SQ_K2: begin
                    if (hit[C_SET]) begin
                        nxt = SQ_PASS; key_step = 1'b1; set_req = 1'b1;
                    end
                    else if (hit[C_ARM])  begin nxt = SQ_D3; key_step = 1'b1; end
                    else if (hit[C_LEAD]) begin nxt = SQ_K1; key_step = 1'b1; end
                    else                        nxt = SQ_IDLE;
                end
                SQ_D3: begin
                    if (hit[C_LEAD]) begin nxt = SQ_D4; key_step = 1'b1; end
                    else                   nxt = SQ_IDLE;
                end
                SQ_D4: begin
                    if (hit[C_MID])       begin nxt = SQ_D5; key_step = 1'b1; end
                    else if (hit[C_LEAD]) begin nxt = SQ_K1; key_step = 1'b1; end
                    else                        nxt = SQ_IDLE;
                end
                SQ_D5: begin
                    if (hit[C_CLR]) begin
                        nxt = SQ_IDLE; key_step = 1'b1; clr_req = 1'b1;
                    end
                    else if (hit[C_LEAD]) begin nxt = SQ_K1; key_step = 1'b1; end
                    else                        nxt = SQ_IDLE;
                end
                SQ_PASS: nxt = SQ_PASS;
                default: nxt = SQ_IDLE;
            endcase
        end
    end

    // Sequence state register; reset abandons any key.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= SQ_IDLE;
        else        st_q <= nxt;
    end

    assign pass_eff = (eff == SQ_PASS);

endmodule

// File: rtl/wpk_prot_store.sv
// Retained protect flag. Reset does not clear it; the power-on value is a
// parameter.
// Assumes: set and clear are never requested together.
module wpk_prot_store #(
    parameter logic INIT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic prot
);

    logic prot_q = INIT;

    // Flag update; frozen while the detector is held in reset.
    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (set_req)      prot_q <= 1'b1;
            else if (clr_req) prot_q <= 1'b0;
        end
    end

    assign prot = prot_q;

endmodule

// File: rtl/wpk_guard.sv
// Top: write-protection key detector. Gives a per-write commit decision
// and the retained protect flag.
// Assumes: wr_valid marks writes already accepted by the controller, and
// win_expire comes from the controller's page-load timer.
module wpk_guard
    import wpk_pkg::*;
#(
    parameter int                ADDR_W     = 13,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = 13'h1555,
    parameter logic [ADDR_W-1:0] KEY_ADDR_B = 13'h0AAA,
    parameter logic [DATA_W-1:0] KEY_LEAD   = 8'hAA,
    parameter logic [DATA_W-1:0] KEY_MID    = 8'h55,
    parameter logic [DATA_W-1:0] KEY_SET    = 8'hA0,
    parameter logic [DATA_W-1:0] KEY_ARM    = 8'h80,
    parameter logic [DATA_W-1:0] KEY_CLR    = 8'h20,
    parameter logic              INIT_PROT  = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              win_expire,
    output logic              prot_o,
    output logic              commit_ok
);

    logic [NCODE-1:0][ADDR_W-1:0] code_addr;
    logic [NCODE-1:0][DATA_W-1:0] code_data;
    logic [NCODE-1:0]             hit;
    logic                         set_req, clr_req, key_step, pass_eff;

    // Key code table built from parameters.
    always_comb begin
        code_addr[C_LEAD] = KEY_ADDR_A; code_data[C_LEAD] = KEY_LEAD;
        code_addr[C_MID]  = KEY_ADDR_B; code_data[C_MID]  = KEY_MID;
        code_addr[C_SET]  = KEY_ADDR_A; code_data[C_SET]  = KEY_SET;
        code_addr[C_ARM]  = KEY_ADDR_A; code_data[C_ARM]  = KEY_ARM;
        code_addr[C_CLR]  = KEY_ADDR_A; code_data[C_CLR]  = KEY_CLR;
    end

    wpk_code_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NC(NCODE)) u_match (
        .addr(wr_addr), .data(wr_data),
        .code_addr(code_addr), .code_data(code_data), .hit(hit)
    );

    wpk_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .win_expire(win_expire),
        .hit(hit), .set_req(set_req), .clr_req(clr_req),
        .key_step(key_step), .pass_eff(pass_eff)
    );

    wpk_prot_store #(.INIT(INIT_PROT)) u_store (
        .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
        .prot(prot_o)
    );

    // Commit decision: data writes only, and only if unprotected or window open.
    assign commit_ok = rst_n && wr_valid && !key_step && (!prot_o || pass_eff);

endmodule

// File: rtl/wpk_guard_chk.sv
// Property checker for wpk_guard, attached by bind.
// Assumes: signal names of the top module as bound below.
module wpk_guard_chk #(
    parameter int                ADDR_W     = 13,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = 13'h1555,
    parameter logic [DATA_W-1:0] KEY_SET    = 8'hA0,
    parameter logic [DATA_W-1:0] KEY_CLR    = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_valid,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              win_expire,
    input logic              prot_o,
    input logic              commit_ok,
    input logic              key_step,
    input logic              pass_eff
);

    // R2
    commit_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ok |-> wr_valid);

    // R3
    set_by_arm_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_o) |-> $past(wr_valid && wr_addr == KEY_ADDR_A && wr_data == KEY_SET));

    // R4
    key_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_step |-> !commit_ok);

    // R5
    protected_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_o && !pass_eff) |-> !commit_ok);

    // R7
    clear_by_release_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_o) |-> $past(wr_valid && wr_addr == KEY_ADDR_A && wr_data == KEY_CLR));

    // R9
    expire_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_expire && !wr_valid) |=> !pass_eff);

    // R10
    reset_keeps_flag_chk: assert property (@(posedge clk)
        !rst_n |=> (prot_o == $past(prot_o)));

    // R10
    reset_no_commit_chk: assert property (@(posedge clk)
        !rst_n |-> !commit_ok);

endmodule

bind wpk_guard wpk_guard_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR_A(KEY_ADDR_A),
    .KEY_SET(KEY_SET), .KEY_CLR(KEY_CLR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .win_expire(win_expire), .prot_o(prot_o),
    .commit_ok(commit_ok), .key_step(key_step), .pass_eff(pass_eff)
);

// File: tb/wpk_guard_bench.sv
// Scoreboard bench: driver tasks queue expected results, a monitor compares.
module wpk_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        win_expire = 1'b0;
    logic        prot_o, commit_ok;

    typedef struct {
        logic  c;
        logic  p;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    always #2 clk = ~clk;

    wpk_guard u_wpk_guard (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .win_expire(win_expire), .prot_o(prot_o),
        .commit_ok(commit_ok)
    );

    // Monitor: compare each accepted write against the queued expectation.
    always @(negedge clk) begin
        if (rst_n === 1'b1 && wr_valid === 1'b1) begin
            n_vec++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL unexpected write: commit=%b prot=%b expected none", commit_ok, prot_o);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (commit_ok !== e.c || prot_o !== e.p) begin
                    n_bad++;
                    $display("FAIL %s: commit=%b prot=%b expected commit=%b prot=%b",
                             e.tag, commit_ok, prot_o, e.c, e.p);
                end
            end
        end
    end

    // Drive one write (optionally with timer expiry); expect commit c, flag p.
    task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic x,
                      input logic c, input logic p, input string tag);
        exp_t e;
        e.c = c; e.p = p; e.tag = tag;
        q.push_back(e);
        wr_valid = 1'b1; wr_addr = a; wr_data = d; win_expire = x;
        @(posedge clk); #1;
        wr_valid = 1'b0; win_expire = 1'b0;
    endtask

    // One-cycle page-load timer expiry with no write.
    task automatic expire();
        win_expire = 1'b1;
        @(posedge clk); #1;
        win_expire = 1'b0;
    endtask

    // Direct check of idle outputs.
    task automatic chk_idle(input logic p, input string tag);
        @(negedge clk);
        n_vec++;
        if (prot_o !== p || commit_ok !== 1'b0) begin
            n_bad++;
            $display("FAIL %s: prot=%b commit=%b expected prot=%b commit=0", tag, prot_o, commit_ok, p);
        end
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: power-on flag value and idle outputs
        chk_idle(1'b0, "R1 reset state");
        // R2: plain write while unprotected
        wr(13'h0123, 8'h11, 0, 1, 0, "R2 plain write");
        // R3/R4/R6: arming key from unprotected, then page writes
        wr(13'h1555, 8'hAA, 0, 0, 0, "R4 lead step");
        wr(13'h0AAA, 8'h55, 0, 0, 0, "R4 mid step");
        wr(13'h1555, 8'hA0, 0, 0, 0, "R4 set step");
        wr(13'h0040, 8'h01, 0, 1, 1, "R3 flag set, R6 page write");
        wr(13'h0041, 8'h02, 0, 1, 1, "R6 page write");
        expire();
        // R5: ordinary write blocked
        wr(13'h0200, 8'h03, 0, 0, 1, "R5 protected write");
        // R6: unlock key while protected, key-like data in window, expiry with write
        wr(13'h1555, 8'hAA, 0, 0, 1, "R4 lead step protected");
        wr(13'h0AAA, 8'h55, 0, 0, 1, "R4 mid step protected");
        wr(13'h1555, 8'hA0, 0, 0, 1, "R4 set step protected");
        wr(13'h0300, 8'h04, 0, 1, 1, "R6 window write");
        wr(13'h1555, 8'hAA, 0, 1, 1, "R6 key-like data in window");
        wr(13'h0310, 8'h05, 1, 0, 1, "R9 write with expiry");
        wr(13'h0302, 8'h06, 0, 0, 1, "R6 window closed");
        // R8: wrong middle byte breaks the key
        wr(13'h1555, 8'hAA, 0, 0, 1, "R8 lead");
        wr(13'h0AAA, 8'h12, 0, 0, 1, "R8 wrong byte");
        wr(13'h0AAA, 8'h55, 0, 0, 1, "R8 stray mid");
        wr(13'h1555, 8'hA0, 0, 0, 1, "R8 stray set");
        wr(13'h0400, 8'h07, 0, 0, 1, "R8 no window after broken key");
        // R8: repeated lead byte restarts the key
        wr(13'h1555, 8'hAA, 0, 0, 1, "R8 lead");
        wr(13'h1555, 8'hAA, 0, 0, 1, "R8 lead again");
        wr(13'h0AAA, 8'h55, 0, 0, 1, "R8 mid");
        wr(13'h1555, 8'hA0, 0, 0, 1, "R8 set");
        wr(13'h0500, 8'h08, 0, 1, 1, "R8 window after restart");
        expire();
        // R9: expiry between steps abandons the key
        wr(13'h1555, 8'hAA, 0, 0, 1, "R9 lead");
        wr(13'h0AAA, 8'h55, 0, 0, 1, "R9 mid");
        expire();
        wr(13'h1555, 8'hA0, 0, 0, 1, "R9 set after expiry");
        wr(13'h0600, 8'h09, 0, 0, 1, "R9 no window");
        // R10: reset mid-key keeps flag, drops key, blocks commit
        wr(13'h1555, 8'hAA, 0, 0, 1, "R10 lead");
        wr(13'h0AAA, 8'h55, 0, 0, 1, "R10 mid");
        rst_n = 1'b0; wr_valid = 1'b1; wr_addr = 13'h0900; wr_data = 8'h0A;
        @(negedge clk);
        n_vec++;
        if (commit_ok !== 1'b0) begin
            n_bad++;
            $display("FAIL R10 commit in reset: commit=%b expected 0", commit_ok);
        end
        @(posedge clk); #1 wr_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_idle(1'b1, "R10 flag kept over reset");
        wr(13'h1555, 8'hA0, 0, 0, 1, "R10 set after reset");
        wr(13'h0901, 8'h0B, 0, 0, 1, "R10 no window");
        // R7: release key clears protection
        wr(13'h1555, 8'hAA, 0, 0, 1, "R7 step1");
        wr(13'h0AAA, 8'h55, 0, 0, 1, "R7 step2");
        wr(13'h1555, 8'h80, 0, 0, 1, "R7 step3");
        wr(13'h1555, 8'hAA, 0, 0, 1, "R7 step4");
        wr(13'h0AAA, 8'h55, 0, 0, 1, "R7 step5");
        wr(13'h1555, 8'h20, 0, 0, 1, "R7 step6");
        wr(13'h0700, 8'h0C, 0, 1, 0, "R7 flag cleared");
        // R4/R8: unprotected lead byte not committed; mismatch after it commits
        wr(13'h1555, 8'hAA, 0, 0, 0, "R4 lead unprotected");
        wr(13'h0800, 8'h33, 0, 1, 0, "R8 mismatch commits");
        // R7: release key while unprotected keeps flag low, no key write commits
        wr(13'h1555, 8'hAA, 0, 0, 0, "R4 release step1");
        wr(13'h0AAA, 8'h55, 0, 0, 0, "R4 release step2");
        wr(13'h1555, 8'h80, 0, 0, 0, "R4 release step3");
        wr(13'h1555, 8'hAA, 0, 0, 0, "R4 release step4");
        wr(13'h0AAA, 8'h55, 0, 0, 0, "R4 release step5");
        wr(13'h1555, 8'h20, 0, 0, 0, "R4 release step6");
        wr(13'h0A00, 8'h0D, 0, 1, 0, "R7 still unprotected");
        @(negedge clk);
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: %0d expectations left, expected 0", q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        #(4 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule